// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact 32-bit processor core that retires one instruction on every rising clock edge. It fetches from an external instruction memory by presenting a word address and taking the returned instruction word in the same cycle. It reaches an external data memory through a word address, a write-data bus, a read-data bus and a write strobe. Both memories sit outside the core and respond combinationally.

The instruction set covers five register-to-register operations: add, sub, and, or, and set-on-less-than. It also has a word load, a word store, a branch taken on equality and an unconditional jump. Inside the core are a program counter with a three-way next-address choice, a 32-entry register file with two read ports and one write port, an ALU with a zero flag, a sign extender, and a combinational decoder. Every result, memory strobe and next address is formed combinationally from the current instruction, and it is committed on the next rising edge.

Top module: `rv_core_top`

## Requirements
- R1: While the active-low reset is asserted, the program counter is 0, every register is cleared and the data write strobe stays low. The first instruction after release executes from word address 0.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by 4. The instruction word address output is PC bits [IADDR_W+1:2].
- R3: Opcode 0 with funct 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs&rt or rs|rt into register rd. The fields are rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0].
- R4: Opcode 0 with funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise. This stays correct when rs-rt overflows.
- R5: Opcode 0x23 (load) forms the address rs plus the immediate [15:0] sign-extended by copying bit 15 into bits 31..16. It drives address bits [DADDR_W+1:2] on the data address output and writes the returned read data into rt.
- R6: Opcode 0x2B (store) raises the write strobe for that cycle only. It drives the same address as a load and puts the value of rt on the write-data bus.
- R7: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate times 4. If they differ, the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to PC+4 bits [31:28], then instruction bits [25:0], then two zero bits.
- R9: Register 0 always reads as zero, and writes that target it are discarded.
- R10: An instruction that reads and writes the same register reads the value held before its own write.
- R11: Any other opcode, and any funct under opcode 0 not listed above, changes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | IADDR_W | Instruction word address (PC without its two low bits) |
| imemData | input | 32 | Instruction returned for imemAddr in the same cycle |
| dmemAddr | output | DADDR_W | Data word address taken from the computed byte address |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Data write strobe, high for one cycle per store |
| dmemRdata | input | 32 | Load data returned for dmemAddr in the same cycle |

## Verification
Two things can happen in one cycle. The register file is read for operands, and in the same cycle the result of that instruction is written back to one of the registers it just read. The bench provokes this with an add whose destination is also a source, then stores that register. The stored value must be the doubled old value, not a doubled doubled value. The bench also runs a set-less-than whose subtraction overflows against one whose subtraction does not. This exposes a comparison that looks only at the sign of the difference, and the result is judged through later stores on the data bus.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;

  localparam int XLEN  = 32;
  localparam int REGAW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } aluOp_e;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_JUMP   = 2'd1,
    PC_BRANCH = 2'd2
  } pcSel_e;

  typedef struct packed {
    logic   regWe;
    logic   dstIsRd;
    logic   srcImm;
    logic   memToReg;
    logic   memWe;
    logic   isBranch;
    logic   isJump;
    logic   setLess;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/rv_core_alu.sv
module rv_core_alu
  import rv_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOp_e       op,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         lessThan
);

  logic [W-1:0] diff;
  logic         overflow;

  assign diff     = opA - opB;
  // subtraction overflows when operand signs differ and the result sign flips
  assign overflow = (opA[W-1] ^ opB[W-1]) & (diff[W-1] ^ opA[W-1]);
  assign lessThan = diff[W-1] ^ overflow;

  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = diff;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/rv_core_regfile.sv
module rv_core_regfile
  import rv_core_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REGAW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  output logic [W-1:0]  rdDataA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);

  localparam int NREGS = 1 << AW;

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  // R9: slot zero never holds anything but zero
  a_r9_slot0_clear: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);

  // R10: a write issued this cycle is visible in the array after the edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr != '0)) |=> (regs[$past(wrAddr)] == $past(wrData)));

endmodule

// File: rtl/rv_core_control.sv
module rv_core_control
  import rv_core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    ctrl          = '0;
    ctrl.aluOp    = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dstIsRd = 1'b1;
        unique case (funct)
          FN_ADD: begin ctrl.regWe = 1'b1; ctrl.aluOp = ALU_ADD; end
          FN_SUB: begin ctrl.regWe = 1'b1; ctrl.aluOp = ALU_SUB; end
          FN_AND: begin ctrl.regWe = 1'b1; ctrl.aluOp = ALU_AND; end
          FN_OR:  begin ctrl.regWe = 1'b1; ctrl.aluOp = ALU_OR;  end
          FN_SLT: begin
            ctrl.regWe   = 1'b1;
            ctrl.aluOp   = ALU_SUB;
            ctrl.setLess = 1'b1;
          end
          default: ctrl.regWe = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.regWe    = 1'b1;
        ctrl.srcImm   = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      OP_STORE: begin
        ctrl.srcImm = 1'b1;
        ctrl.memWe  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.isBranch = 1'b1;
        ctrl.aluOp    = ALU_SUB;
      end
      OP_JUMP: ctrl.isJump = 1'b1;
      default: ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/rv_core_datapath.sv
module rv_core_datapath
  import rv_core_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int IADDR_W = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        instr,
  input  ctrl_t              ctrl,
  output logic [IADDR_W-1:0] imemAddr,
  output logic [DADDR_W-1:0] dmemAddr,
  output logic [W-1:0]       dmemWdata,
  input  logic [W-1:0]       dmemRdata
);

  localparam int HALF = 16;

  logic [W-1:0]     pc, pcNext, pcPlus4, branchTarget, jumpTarget;
  logic [W-1:0]     immExt, rsData, rtData, aluB, aluRes, wbData;
  logic [REGAW-1:0] rsAddr, rtAddr, rdAddr, wrAddr;
  logic             aluZero, aluLess;
  pcSel_e           pcSel;

  assign rsAddr = instr[25:21];
  assign rtAddr = instr[20:16];
  assign rdAddr = instr[15:11];

  // sign extension: bit 15 replicated into the upper half
  assign immExt = {{(W-HALF){instr[HALF-1]}}, instr[HALF-1:0]};

  rv_core_regfile #(.W(W), .AW(REGAW)) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (rsAddr),
    .rdDataA (rsData),
    .rdAddrB (rtAddr),
    .rdDataB (rtData),
    .wrEn    (ctrl.regWe),
    .wrAddr  (wrAddr),
    .wrData  (wbData)
  );

  assign aluB = ctrl.srcImm ? immExt : rtData;

  rv_core_alu #(.W(W)) uAlu (
    .opA      (rsData),
    .opB      (aluB),
    .op       (ctrl.aluOp),
    .result   (aluRes),
    .zero     (aluZero),
    .lessThan (aluLess)
  );

  assign wrAddr = ctrl.dstIsRd ? rdAddr : rtAddr;

  always_comb begin
    if (ctrl.memToReg)     wbData = dmemRdata;
    else if (ctrl.setLess) wbData = {{(W-1){1'b0}}, aluLess};
    else                   wbData = aluRes;
  end

  assign pcPlus4      = pc + W'(4);
  assign branchTarget = pcPlus4 + {immExt[W-3:0], 2'b00};
  assign jumpTarget   = {pcPlus4[W-1:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.isJump)                  pcSel = PC_JUMP;
    else if (ctrl.isBranch && aluZero) pcSel = PC_BRANCH;
    else                              pcSel = PC_SEQ;
  end

  always_comb begin
    unique case (pcSel)
      PC_JUMP:   pcNext = jumpTarget;
      PC_BRANCH: pcNext = branchTarget;
      default:   pcNext = pcPlus4;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end

  assign imemAddr  = pc[IADDR_W+1:2];
  assign dmemAddr  = aluRes[DADDR_W+1:2];
  assign dmemWdata = rtData;

  // R2: sequential flow steps by one word
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == PC_SEQ) |=> (pc == $past(pc) + W'(4)));

  // R7: taken branch lands at PC+4+offset*4
  a_r7_branch_target: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == PC_BRANCH) |=>
      (pc == $past(pc) + W'(4) + {$past(immExt[W-3:0]), 2'b00}));

  // R8: jump carries the 26-bit field into PC bits 27..2, word aligned
  a_r8_jump_field: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == PC_JUMP) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

endmodule

// File: rtl/rv_core_top.sv
module rv_core_top
  import rv_core_pkg::*;
#(
  parameter int IADDR_W = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [IADDR_W-1:0] imemAddr,
  input  logic [31:0]        imemData,
  output logic [DADDR_W-1:0] dmemAddr,
  output logic [XLEN-1:0]    dmemWdata,
  output logic               dmemWe,
  input  logic [XLEN-1:0]    dmemRdata
);

  ctrl_t ctrl;

  rv_core_control uCtrl (
    .instr (imemData),
    .ctrl  (ctrl)
  );

  rv_core_datapath #(
    .W       (XLEN),
    .IADDR_W (IADDR_W),
    .DADDR_W (DADDR_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .instr     (imemData),
    .ctrl      (ctrl),
    .imemAddr  (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemRdata (dmemRdata)
  );

  assign dmemWe = ctrl.memWe & rstN;

  // R1: no store strobe escapes while reset is held
  always_comb begin
    if (!rstN) a_r1_quiet_reset: assert (!dmemWe);
  end

  // R6: a store never also writes a register or redirects the PC
  a_r6_store_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    dmemWe |-> (!ctrl.regWe && !ctrl.isBranch && !ctrl.isJump));

endmodule

// File: tb/tb_rv_core_top.sv
`timescale 1ns/1ps
module tb_rv_core_top;

  localparam real CLK_NS = 4.0;

  typedef struct packed {
    logic [31:0] instr;
    logic [7:0]  pcW;
    logic        isSt;
    logic        chkAddr;
    logic [7:0]  addrW;
    logic [31:0] wdata;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] rType(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] iType(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] jType(input logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  localparam int NVEC = 30;
  localparam vec_t VEC [NVEC] = '{
    '{iType(6'h2B, 0, 31, 16'd48),     8'd0,  1'b1, 1'b1, 8'd12,  32'h0000_0000, 4'd1},  // R1 cleared reg
    '{iType(6'h23, 0, 1, 16'd20),      8'd1,  1'b0, 1'b1, 8'h05,  32'h0,         4'd5},  // R5
    '{iType(6'h23, 0, 2, 16'h01FC),    8'd2,  1'b0, 1'b1, 8'h7F,  32'h0,         4'd5},  // R5
    '{iType(6'h23, 0, 3, 16'h0200),    8'd3,  1'b0, 1'b1, 8'h80,  32'h0,         4'd5},  // R5
    '{iType(6'h23, 0, 4, 16'hFFFC),    8'd4,  1'b0, 1'b1, 8'hFF,  32'h0,         4'd5},  // R5 sign ext
    '{rType(1, 2, 5, 6'h20),           8'd5,  1'b0, 1'b0, 8'h00,  32'h0,         4'd3},  // R3 add
    '{iType(6'h2B, 0, 5, 16'd0),       8'd6,  1'b1, 1'b1, 8'd0,   32'h8400_0084, 4'd3},  // R3
    '{rType(1, 2, 6, 6'h22),           8'd7,  1'b0, 1'b0, 8'h00,  32'h0,         4'd3},  // R3 sub
    '{iType(6'h2B, 0, 6, 16'd4),       8'd8,  1'b1, 1'b1, 8'd1,   32'h85FF_FF86, 4'd3},  // R3
    '{rType(3, 4, 7, 6'h24),           8'd9,  1'b0, 1'b0, 8'h00,  32'h0,         4'd3},  // R3 and
    '{rType(1, 4, 8, 6'h25),           8'd10, 1'b0, 1'b0, 8'h00,  32'h0,         4'd3},  // R3 or
    '{iType(6'h2B, 0, 7, 16'd8),       8'd11, 1'b1, 1'b1, 8'd2,   32'h8000_0080, 4'd3},  // R3
    '{iType(6'h2B, 0, 8, 16'd12),      8'd12, 1'b1, 1'b1, 8'd3,   32'hFF00_00FF, 4'd3},  // R3
    '{rType(2, 3, 9, 6'h2A),           8'd13, 1'b0, 1'b0, 8'h00,  32'h0,         4'd4},  // R4 ovf, false
    '{rType(3, 2, 10, 6'h2A),          8'd14, 1'b0, 1'b0, 8'h00,  32'h0,         4'd4},  // R4 ovf, true
    '{rType(1, 2, 11, 6'h2A),          8'd15, 1'b0, 1'b0, 8'h00,  32'h0,         4'd4},  // R4 plain true
    '{rType(1, 1, 12, 6'h2A),          8'd16, 1'b0, 1'b0, 8'h00,  32'h0,         4'd4},  // R4 equal
    '{iType(6'h2B, 0, 9, 16'd16),      8'd17, 1'b1, 1'b1, 8'd4,   32'h0,         4'd4},  // R4
    '{iType(6'h2B, 0, 10, 16'd20),     8'd18, 1'b1, 1'b1, 8'd5,   32'h1,         4'd4},  // R4
    '{iType(6'h2B, 0, 11, 16'd24),     8'd19, 1'b1, 1'b1, 8'd6,   32'h1,         4'd4},  // R4
    '{iType(6'h2B, 0, 12, 16'd28),     8'd20, 1'b1, 1'b1, 8'd7,   32'h0,         4'd4},  // R4
    '{rType(1, 1, 0, 6'h20),           8'd21, 1'b0, 1'b0, 8'h00,  32'h0,         4'd9},  // R9 write r0
    '{iType(6'h2B, 0, 0, 16'd32),      8'd22, 1'b1, 1'b1, 8'd8,   32'h0,         4'd9},  // R9
    '{iType(6'h04, 1, 2, 16'd5),       8'd23, 1'b0, 1'b0, 8'h00,  32'h0,         4'd7},  // R7 not taken
    '{iType(6'h04, 1, 1, 16'd2),       8'd24, 1'b0, 1'b0, 8'h00,  32'h0,         4'd7},  // R7 taken fwd
    '{iType(6'h04, 0, 0, 16'hFFFD),    8'd27, 1'b0, 1'b0, 8'h00,  32'h0,         4'd7},  // R7 taken back
    '{jType(26'd41),                   8'd25, 1'b0, 1'b0, 8'h00,  32'h0,         4'd8},  // R8 jump
    '{rType(1, 1, 1, 6'h20),           8'd41, 1'b0, 1'b0, 8'h00,  32'h0,         4'd10}, // R10 same reg
    '{iType(6'h2B, 0, 1, 16'd40),      8'd42, 1'b1, 1'b1, 8'd10,  32'h0A00_000A, 4'd10}, // R10
    '{iType(6'h2B, 0, 2, 16'h03FC),    8'd43, 1'b1, 1'b1, 8'hFF,  32'h7F00_007F, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  imemAddr;
  logic [31:0] imemData = '0;
  logic [7:0]  dmemAddr;
  logic [31:0] dmemWdata;
  logic        dmemWe;
  logic [31:0] dmemRdata;
  int          nChecks = 0;
  int          nFails  = 0;
  logic        finished = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  // data memory model: word w returns {w, 16'h0000, w}
  assign dmemRdata = {dmemAddr, 16'h0000, dmemAddr};

  rv_core_top dut (
    .clk       (clk),
    .rstN      (rstN),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemWe    (dmemWe),
    .dmemRdata (dmemRdata)
  );

  task automatic checkOut(input string tag, input logic [7:0] pcW, input logic st,
                          input logic chkA, input logic [7:0] aW, input logic [31:0] wd);
    logic bad;
    bad = (imemAddr !== pcW) || (dmemWe !== st) ||
          (chkA && (dmemAddr !== aW)) || (st && (dmemWdata !== wd));
    nChecks++;
    if (bad) begin
      nFails++;
      $display("FAIL %s: pc=%0d we=%0b addr=%0h wdata=%h, expected pc=%0d we=%0b addr=%0h wdata=%h",
               tag, imemAddr, dmemWe, dmemAddr, dmemWdata, pcW, st, aW, wd);
    end
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds PC at 0 and blocks a store presented during reset
    imemData = iType(6'h2B, 0, 0, 16'd0);
    repeat (3) @(negedge clk);
    #0.5;
    checkOut("R1 in reset", 8'd0, 1'b0, 1'b0, 8'd0, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      imemData = VEC[i].instr;
      #0.5;
      checkOut($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].pcW, VEC[i].isSt,
               VEC[i].chkAddr, VEC[i].addrW, VEC[i].wdata);
      @(negedge clk);
    end

    // R11: unknown opcode with rt=1 must not write r1
    imemData = 32'hFC21_FFFF;
    #0.5;
    checkOut("R11 bad opcode", 8'd44, 1'b0, 1'b0, 8'd0, 32'h0);
    @(negedge clk);
    // R11: opcode 0 with unlisted funct 0, rd=1
    imemData = rType(1, 1, 1, 6'h00);
    #0.5;
    checkOut("R11 bad funct", 8'd45, 1'b0, 1'b0, 8'd0, 32'h0);
    @(negedge clk);
    imemData = iType(6'h2B, 0, 1, 16'd44);
    #0.5;
    checkOut("R11 r1 intact", 8'd46, 1'b1, 1'b1, 8'd11, 32'h0A00_000A);
    @(negedge clk);

    // R1: mid-run reset returns PC to 0 and clears registers
    rstN = 1'b0;
    imemData = iType(6'h2B, 0, 1, 16'd0);
    #0.5;
    checkOut("R1 async reset", 8'd0, 1'b0, 1'b1, 8'd0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    checkOut("R1 regs cleared", 8'd0, 1'b1, 1'b1, 8'd0, 32'h0);
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule